// File: doc/BRIEF.md
# Pulse-Per-Second Phase Error Meter

This block measures how far a local oscillator has drifted against a one-pulse-per-second timing reference. A fixed modulo-N divider counts oscillator ticks and produces one wrap event per N ticks. With the default N of ten million and a 10 MHz oscillator, that is one event per second. Before each measurement the divider is forced to zero by a reference edge, so the next wrap and the next reference edge should coincide when the oscillator is exact.

The block then counts the interval between the two edges. It counts only while exactly one of the two events has been seen, which is the exclusive-or of the two. It also records which edge came first. The count can advance on every cycle of the fast sampling clock for fine resolution, or only on oscillator ticks for a wider range.

The oscillator reaches the block as a one-cycle `osc_tick` strobe in the sampling clock domain. A controller waits for the active-low ready flag, then reads the signed result in two halves over a narrow bus. Pulsing `clear` starts the next cycle of alignment and measurement, so one result is produced per two reference periods. Control and status pins are plain levels and strobes, with no stream handshake. The result is held until `clear`, so no back-pressure is ever needed.

Top module: `pps_phase_meter`

## Requirements
- R1: After reset, `rdy_n` is 1, `ovf` is 0 and `rd_bus` reads 0 for either value of `half_sel`.
- R2: The divider counts `osc_tick` strobes modulo DIV_N and is forced to zero by the first reference rising edge after reset or `clear`. The divider wrap is the DIV_N-th tick after that edge, so a reference period of exactly DIV_N ticks gives a magnitude of 0. No result is flagged before the second reference edge.
- R3: `pps_in` passes through a two-flop synchronizer, and only its rising edges act. A level held high for many cycles counts as one edge.
- R4: While exactly one of the two edges (divider wrap, reference) has been seen, the magnitude increments once per cycle when `fine_sel`=1, or once per `osc_tick` cycle when `fine_sel`=0. It stops on the cycle the other edge arrives.
- R5: The sign bit is 1 when the divider wrap arrives strictly before the reference edge. It is 0 when the reference edge arrives first or both arrive in the same cycle.
- R6: The magnitude is 9 bits wide. At 511 it saturates instead of wrapping, and a further count sets `ovf`, which stays 1 until `clear`.
- R7: `rdy_n` goes low once both edges have been seen. While it is low, the result is frozen and further reference edges have no effect.
- R8: A `clear` pulse makes `rdy_n` 1 and resets magnitude, sign and `ovf` to 0 from the next cycle. A new result then needs one aligning reference edge and one measuring reference edge.
- R9: With `half_sel`=0, `rd_bus[4:0]` carries magnitude bits 4:0. With `half_sel`=1, `rd_bus[4]` carries the sign and `rd_bus[3:0]` carries magnitude bits 8:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (fast system clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period, synchronous to clk |
| fine_sel | input | 1 | 1: count every clk cycle; 0: count only on osc_tick |
| pps_in | input | 1 | Asynchronous one-pulse-per-second reference |
| clear | input | 1 | One-cycle restart of alignment and measurement |
| half_sel | input | 1 | Selects which half of the result drives rd_bus |
| rd_bus | output | 5 | Selected result half |
| rdy_n | output | 1 | Low while a result is valid and held |
| ovf | output | 1 | Sticky saturation flag |

## Verification
A divider that is misaligned or counts the wrong modulus shows as a nonzero magnitude on a run whose reference period matches the divider exactly. It can be seen on the first read after `rdy_n` falls. A gate that opens or closes one cycle off shifts every magnitude by one count. A swapped sign shows in bit 4 of the high half on every non-coincident run. A synchronizer that lets a held level act twice, or a hold state that does not ignore the reference, shows as an early `rdy_n` or a changed read within a few cycles of the extra edge.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  typedef enum logic [1:0] {
    PH_ALIGN   = 2'd0,
    PH_MEASURE = 2'd1,
    PH_HOLD    = 2'd2
  } phase_e;
endpackage

// File: rtl/ppm_edge_sync.sv
module ppm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;

  // R3
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ppm_divider.sv
module ppm_divider #(
  parameter int DIV_N = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic wrap
);
  localparam int DIV_W = $clog2(DIV_N);
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_N - 1);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= '0;
    else if (tick)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign wrap = tick & (cnt == LAST) & ~restart;

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R2
  div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !wrap);
endmodule

// File: rtl/ppm_gated_counter.sv
module ppm_gated_counter #(
  parameter int MAG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             arm,
  input  logic             div_hit,
  input  logic             ref_hit,
  input  logic             cnt_en,
  output logic             closing,
  output logic [MAG_W-1:0] mag,
  output logic             sign,
  output logic             ovf
);
  localparam logic [MAG_W-1:0] MAG_MAX = '1;

  logic div_seen, ref_seen;
  logic gate, div_now, ref_now;

  assign gate    = div_seen ^ ref_seen;
  assign div_now = div_seen | (arm & div_hit);
  assign ref_now = ref_seen | (arm & ref_hit);
  assign closing = arm & div_now & ref_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_seen <= 1'b0;
      ref_seen <= 1'b0;
      mag      <= '0;
      sign     <= 1'b0;
      ovf      <= 1'b0;
    end else if (clr) begin
      div_seen <= 1'b0;
      ref_seen <= 1'b0;
      mag      <= '0;
      sign     <= 1'b0;
      ovf      <= 1'b0;
    end else if (arm) begin
      div_seen <= div_now;
      ref_seen <= ref_now;
      if (div_hit && !div_seen && !ref_seen && !ref_hit)
        sign <= 1'b1;
      if (gate && cnt_en) begin
        if (mag == MAG_MAX) ovf <= 1'b1;
        else                mag <= mag + 1'b1;
      end
    end
  end

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr |=> ovf);
  // R6
  mag_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mag == MAG_MAX) && !clr |=> (mag == MAG_MAX));
  // R6
  ovf_needs_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (mag == MAG_MAX));
  // R4
  idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm && !clr |=> $stable(mag));
endmodule

// File: rtl/pps_phase_meter.sv
module pps_phase_meter #(
  parameter int DIV_N       = 10_000_000,
  parameter int MAG_W       = 9,
  parameter int SYNC_STAGES = 2,
  localparam int BUS_W      = (MAG_W + 2) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             fine_sel,
  input  logic             pps_in,
  input  logic             clear,
  input  logic             half_sel,
  output logic [BUS_W-1:0] rd_bus,
  output logic             rdy_n,
  output logic             ovf
);
  import ppm_pkg::*;

  localparam int HI_W = MAG_W - BUS_W + 1;

  phase_e state, nxt;
  logic pps_rise, restart, wrap, closing, arm, cnt_en, sign;
  logic [MAG_W-1:0] mag;
  logic [BUS_W-1:0] hi_word;

  ppm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pps_in), .rise(pps_rise));

  assign restart = (state == PH_ALIGN) & pps_rise & ~clear;

  ppm_divider #(.DIV_N(DIV_N)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .restart(restart), .wrap(wrap));

  assign arm    = (state == PH_MEASURE) & ~clear;
  assign cnt_en = fine_sel | osc_tick;

  ppm_gated_counter #(.MAG_W(MAG_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clear), .arm(arm),
    .div_hit(wrap), .ref_hit(pps_rise), .cnt_en(cnt_en),
    .closing(closing), .mag(mag), .sign(sign), .ovf(ovf));

  always_comb begin
    nxt = state;
    case (state)
      PH_ALIGN:   if (pps_rise) nxt = PH_MEASURE;
      PH_MEASURE: if (closing)  nxt = PH_HOLD;
      default:    nxt = PH_HOLD;
    endcase
    if (clear) nxt = PH_ALIGN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_ALIGN;
    else        state <= nxt;
  end

  assign rdy_n = (state != PH_HOLD);

  generate
    if (HI_W == BUS_W) begin : g_hi_exact
      assign hi_word = {sign, mag[MAG_W-1:BUS_W]};
    end else begin : g_hi_pad
      assign hi_word = {{(BUS_W-HI_W){1'b0}}, sign, mag[MAG_W-1:BUS_W]};
    end
  endgenerate

  assign rd_bus = half_sel ? hi_word : mag[BUS_W-1:0];

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HOLD) && !clear |=> (state == PH_HOLD) && $stable(mag) && $stable(sign));
  // R8
  clear_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> rdy_n && !ovf && (mag == '0));
  // R2
  align_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_ALIGN) |=> rdy_n);
endmodule

// File: tb/pps_phase_meter_test.sv
module pps_phase_meter_test;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, fine_sel = 1'b0, pps_in = 1'b0, clear = 1'b0, half_sel = 1'b0;
  logic [4:0] rd_bus;
  logic rdy_n, ovf;

  int checks = 0, failures = 0, cyc = 0, tp_mode = 1;
  bit finished = 0;

  pps_phase_meter #(.DIV_N(N)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .fine_sel(fine_sel),
    .pps_in(pps_in), .clear(clear), .half_sel(half_sel),
    .rd_bus(rd_bus), .rdy_n(rdy_n), .ovf(ovf));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) osc_tick <= (tp_mode == 1) || (((cyc + 1) % 2) == 0);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit tick_at(int e, int tp);
    return (tp == 1) || ((e % 2) == 0);
  endfunction

  function automatic int div_edge(int p0, int tp);
    int n = 0;
    for (int e = p0 + 1; e < p0 + 1 + 4 * N; e++)
      if (tick_at(e, tp)) begin
        n++;
        if (n == N) return e;
      end
    return -1;
  endfunction

  function automatic int gated_count(int lo, int hi, int tp, bit fine);
    int c = 0;
    for (int e = lo + 1; e <= hi; e++)
      if (fine || tick_at(e, tp)) c++;
    return c;
  endfunction

  task automatic read_halves(output logic [4:0] lo, output logic [4:0] hi);
    half_sel = 1'b0; #1 lo = rd_bus;
    half_sel = 1'b1; #1 hi = rd_bus;
  endtask

  // one align + measure run; d = reference edge minus divider wrap, in clk edges
  task automatic run_meas(int d, int tp, bit fine, int hold, bit extra_pps);
    int c0, a, b, cnt, emag, wait_n;
    bit esign, eovf;
    logic [4:0] lo, hi;
    @(negedge clk); tp_mode = tp; fine_sel = fine; clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    @(negedge clk);
    read_halves(lo, hi);
    chk("R8 clear rdy_n", rdy_n, 1);
    chk("R8 clear ovf", ovf, 0);
    chk("R8 clear low half", lo, 0);
    chk("R8 clear high half", hi, 0);
    repeat (4) @(negedge clk);
    pps_in = 1'b1; c0 = cyc;
    repeat (hold) @(negedge clk);
    pps_in = 1'b0;
    a = div_edge(c0 + 3, tp);
    b = a + d;
    while (cyc < b - 3) @(negedge clk);
    chk("R2 no result before measuring edge", rdy_n, 1);
    pps_in = 1'b1;
    repeat (3) @(negedge clk);
    pps_in = 1'b0;
    wait_n = 0;
    while (rdy_n !== 1'b0 && wait_n < 3000) begin @(negedge clk); wait_n++; end
    chk("R7 rdy_n low after both edges", rdy_n, 0);
    cnt   = (a < b) ? gated_count(a, b, tp, fine) : gated_count(b, a, tp, fine);
    esign = (a < b);
    eovf  = (cnt > 511);
    emag  = eovf ? 511 : cnt;
    read_halves(lo, hi);
    chk($sformatf("R4 R9 low half d=%0d tp=%0d fine=%0d", d, tp, fine), lo, emag & 31);
    chk($sformatf("R5 R9 high half d=%0d tp=%0d fine=%0d", d, tp, fine), hi,
        (32'(esign) << 4) | (emag >> 5));
    chk($sformatf("R6 ovf d=%0d", d), ovf, eovf);
    if (extra_pps) begin
      pps_in = 1'b1; repeat (3) @(negedge clk); pps_in = 1'b0;
      repeat (8) @(negedge clk);
      read_halves(lo, hi);
      chk("R7 extra edge ignored rdy_n", rdy_n, 0);
      chk("R7 extra edge ignored low", lo, emag & 31);
      chk("R7 extra edge ignored high", hi, (32'(esign) << 4) | (emag >> 5));
    end
  endtask

  initial begin
    logic [4:0] lo, hi;
    process::self().srandom(32'd1234);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_halves(lo, hi);
    chk("R1 reset rdy_n", rdy_n, 1);
    chk("R1 reset ovf", ovf, 0);
    chk("R1 reset low half", lo, 0);
    chk("R1 reset high half", hi, 0);
    run_meas(0, 1, 1, 3, 1);     // R2 exact period
    run_meas(9, 1, 1, 3, 0);     // R5 divider first
    run_meas(-13, 1, 1, 3, 0);   // R5 reference first
    run_meas(5, 1, 1, 30, 0);    // R3 long reference level
    run_meas(7, 2, 0, 3, 0);     // R4 coarse counting
    run_meas(7, 2, 1, 3, 0);     // R4 fine counting
    run_meas(-9, 2, 0, 3, 0);    // R4 coarse, reference first
    run_meas(511, 1, 1, 3, 0);   // R6 at limit
    run_meas(512, 1, 1, 3, 1);   // R6 one past limit
    run_meas(600, 1, 1, 3, 0);   // R6 well past limit
    for (int i = 0; i < 12; i++)
      run_meas(int'($urandom_range(80)) - 30, int'($urandom_range(1)) + 1,
               1'($urandom_range(1)), 3, (i % 4) == 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule